// File: doc/BRIEF.md
# Clamped PI Loop Regulator

This block is a fixed-point proportional-integral regulator for a control loop, for example one that steers an oscillator through a DAC. An upstream phase or frequency detector strobes in one signed error sample at a time. The block adds that sample to a running integrator and forms a weighted sum of the integrator candidate and the raw error. It scales the sum down by the coefficient fraction and adds a fixed offset. It then limits the result to a programmable window and registers it as the actuator word, with a valid strobe.

The gains, offset, limits and the anti-windup switch are static inputs that the surrounding logic holds steady. A synchronous init input restarts the loop by zeroing the integrator only. The anti-windup switch decides what happens to the integrator while the output is pinned at a limit. When it is set, integration is kept only if it pulls the output back toward the allowed window.

Top module: `pi_loop_reg`

## Requirements
- R1: After reset, y_o is 0, y_vld_o is 0 and the integrator is 0.
- R2: Gains carry 12 fractional bits (4096 means 1.0). For an accepted sample inside the limits, y_o = ((cand*ki_i + err_i*kp_i) >>> 12) + bias_i, where cand = integrator + err_i.
- R3: When the computed output lies within [y_min_i, y_max_i], the candidate integrator is always kept.
- R4: A computed output below y_min_i yields y_o = y_min_i. With anti-windup on, the candidate is kept only if it is greater than the old integrator.
- R5: A computed output above y_max_i yields y_o = y_max_i. With anti-windup on, the candidate is kept only if it is less than the old integrator.
- R6: With anti-windup off, the candidate integrator is kept even when the output is clamped.
- R7: init_i zeroes the integrator and leaves every other setting in force. A sample strobed in the same cycle as init_i is discarded and gives no output strobe.
- R8: y_vld_o is high for exactly one cycle, one clock after each accepted sample, and is low otherwise.
- R9: y_o keeps its last value in every cycle without an accepted sample.
- R10: The scaling shift rounds toward minus infinity, so a weighted sum of -1 contributes -1 to the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Synchronous integrator clear |
| aw_en_i | input | 1 | Anti-windup enable |
| kp_i | input | GAIN_W | Signed proportional gain, 12 fractional bits |
| ki_i | input | GAIN_W | Signed integral gain, 12 fractional bits |
| bias_i | input | OUT_W | Signed offset added after scaling |
| y_min_i | input | OUT_W | Signed lower output limit |
| y_max_i | input | OUT_W | Signed upper output limit |
| err_vld_i | input | 1 | Error sample strobe |
| err_i | input | ERR_W | Signed error sample |
| y_vld_o | output | 1 | Output strobe |
| y_o | output | OUT_W | Registered clamped actuator word |

## Verification
A sample accepted at one clock edge shows up on y_o and y_vld_o right after that same edge, so each result is due exactly one clock after its strobe. The integrator update from the same edge shows up only in the next sample's output. The bench drives inputs on the falling edge and updates its behavioural model for that edge. It then compares both outputs just after the following rising edge, once per clock, so every comparison lines up with that one-cycle latency. Integrator behaviour at the limits and after init is checked through the outputs of the following samples.

// File: rtl/pi_reg_pkg.sv
package pi_reg_pkg;

    localparam int PI_FRAC_BITS = 12;
    localparam int PI_ACC_W     = 48;
    localparam int PI_ERR_W     = 24;
    localparam int PI_GAIN_W    = 16;
    localparam int PI_OUT_W     = 18;

    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_LO   = 2'd1,
        CLAMP_HI   = 2'd2
    } clamp_e;

    // Integrator update decision for one sample.
    function automatic logic keep_candidate(input clamp_e dir, input logic aw,
                                            input logic cand_gt, input logic cand_lt);
        case (dir)
            CLAMP_LO: keep_candidate = !aw || cand_gt;
            CLAMP_HI: keep_candidate = !aw || cand_lt;
            default:  keep_candidate = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pi_mac.sv
module pi_mac
    import pi_reg_pkg::*;
#(
    parameter int ERR_W  = PI_ERR_W,
    parameter int GAIN_W = PI_GAIN_W,
    parameter int OUT_W  = PI_OUT_W,
    parameter int ACC_W  = PI_ACC_W,
    parameter int FRAC   = PI_FRAC_BITS
) (
    input  logic signed [ACC_W-1:0]  integ_i,
    input  logic signed [ERR_W-1:0]  err_i,
    input  logic signed [GAIN_W-1:0] kp_i,
    input  logic signed [GAIN_W-1:0] ki_i,
    input  logic signed [OUT_W-1:0]  bias_i,
    output logic signed [ACC_W-1:0]  cand_o,
    output logic signed [ACC_W-1:0]  raw_o
);
    localparam int ERR_PAD  = ACC_W - ERR_W;
    localparam int GAIN_PAD = ACC_W - GAIN_W;
    localparam int OUT_PAD  = ACC_W - OUT_W;

    logic signed [ACC_W-1:0] err_x, kp_x, ki_x, bias_x;
    logic signed [ACC_W-1:0] prod_i, prod_p, sum;

    always_comb begin
        err_x  = signed'({{ERR_PAD{err_i[ERR_W-1]}}, err_i});
        kp_x   = signed'({{GAIN_PAD{kp_i[GAIN_W-1]}}, kp_i});
        ki_x   = signed'({{GAIN_PAD{ki_i[GAIN_W-1]}}, ki_i});
        bias_x = signed'({{OUT_PAD{bias_i[OUT_W-1]}}, bias_i});
        cand_o = integ_i + err_x;
        prod_i = cand_o * ki_x;
        prod_p = err_x * kp_x;
        sum    = prod_i + prod_p;
        raw_o  = (sum >>> FRAC) + bias_x;
    end

endmodule

// File: rtl/pi_clamp.sv
module pi_clamp
    import pi_reg_pkg::*;
#(
    parameter int OUT_W = PI_OUT_W,
    parameter int ACC_W = PI_ACC_W
) (
    input  logic signed [ACC_W-1:0] raw_i,
    input  logic signed [ACC_W-1:0] cand_i,
    input  logic signed [ACC_W-1:0] integ_i,
    input  logic signed [OUT_W-1:0] y_min_i,
    input  logic signed [OUT_W-1:0] y_max_i,
    input  logic                    aw_i,
    output logic signed [OUT_W-1:0] y_o,
    output clamp_e                  dir_o,
    output logic                    keep_o
);
    localparam int OUT_PAD = ACC_W - OUT_W;

    logic signed [ACC_W-1:0] lo_x, hi_x;

    always_comb begin
        lo_x = signed'({{OUT_PAD{y_min_i[OUT_W-1]}}, y_min_i});
        hi_x = signed'({{OUT_PAD{y_max_i[OUT_W-1]}}, y_max_i});
        if (raw_i < lo_x) begin
            dir_o = CLAMP_LO;
            y_o   = y_min_i;
        end else if (raw_i > hi_x) begin
            dir_o = CLAMP_HI;
            y_o   = y_max_i;
        end else begin
            dir_o = CLAMP_NONE;
            y_o   = raw_i[OUT_W-1:0];
        end
        keep_o = keep_candidate(dir_o, aw_i, cand_i > integ_i, cand_i < integ_i);
    end

endmodule

// File: rtl/pi_loop_reg.sv
module pi_loop_reg
    import pi_reg_pkg::*;
#(
    parameter int ERR_W  = PI_ERR_W,
    parameter int GAIN_W = PI_GAIN_W,
    parameter int OUT_W  = PI_OUT_W,
    parameter int ACC_W  = PI_ACC_W,
    parameter int FRAC   = PI_FRAC_BITS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     init_i,
    input  logic                     aw_en_i,
    input  logic signed [GAIN_W-1:0] kp_i,
    input  logic signed [GAIN_W-1:0] ki_i,
    input  logic signed [OUT_W-1:0]  bias_i,
    input  logic signed [OUT_W-1:0]  y_min_i,
    input  logic signed [OUT_W-1:0]  y_max_i,
    input  logic                     err_vld_i,
    input  logic signed [ERR_W-1:0]  err_i,
    output logic                     y_vld_o,
    output logic signed [OUT_W-1:0]  y_o
);
    logic signed [ACC_W-1:0] integ_q;
    logic signed [ACC_W-1:0] cand, raw;
    logic signed [OUT_W-1:0] y_c;
    logic signed [OUT_W-1:0] y_q;
    logic                    vld_q;
    clamp_e                  dir;
    logic                    keep;
    logic                    take;

    assign take = err_vld_i && !init_i;

    pi_mac #(
        .ERR_W(ERR_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W), .ACC_W(ACC_W), .FRAC(FRAC)
    ) mac_i (
        .integ_i(integ_q), .err_i(err_i), .kp_i(kp_i), .ki_i(ki_i),
        .bias_i(bias_i), .cand_o(cand), .raw_o(raw)
    );

    pi_clamp #(
        .OUT_W(OUT_W), .ACC_W(ACC_W)
    ) clamp_i (
        .raw_i(raw), .cand_i(cand), .integ_i(integ_q), .y_min_i(y_min_i),
        .y_max_i(y_max_i), .aw_i(aw_en_i), .y_o(y_c), .dir_o(dir), .keep_o(keep)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q <= '0;
            y_q     <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= take;
            if (init_i) begin
                integ_q <= '0;
            end else if (err_vld_i) begin
                y_q <= y_c;
                if (keep) begin
                    integ_q <= cand;
                end
            end
        end
    end

    assign y_o     = y_q;
    assign y_vld_o = vld_q;

endmodule

// File: rtl/pi_loop_chk.sv
module pi_loop_chk
    import pi_reg_pkg::*;
#(
    parameter int OUT_W = PI_OUT_W,
    parameter int ACC_W = PI_ACC_W
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    init_i,
    input logic                    aw_en_i,
    input logic                    err_vld_i,
    input logic signed [OUT_W-1:0] y_min_i,
    input logic signed [OUT_W-1:0] y_max_i,
    input logic                    y_vld_o,
    input logic signed [OUT_W-1:0] y_o,
    input logic signed [ACC_W-1:0] integ_q,
    input clamp_e                  dir
);
    p_strobe_lat_r8: assert property (@(posedge clk) disable iff (rst)
        (err_vld_i && !init_i) |=> y_vld_o);

    p_strobe_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !(err_vld_i && !init_i) |=> !y_vld_o);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(err_vld_i && !init_i) |=> $stable(y_o));

    // Covers R4 and R5: a fresh output stays inside a fixed window.
    p_in_window_r4: assert property (@(posedge clk) disable iff (rst)
        (y_vld_o && $stable(y_min_i) && $stable(y_max_i) && (y_min_i <= y_max_i))
        |-> (y_o >= y_min_i && y_o <= y_max_i));

    p_init_clear_r7: assert property (@(posedge clk) disable iff (rst)
        init_i |=> (integ_q == '0));

    p_aw_low_r4: assert property (@(posedge clk) disable iff (rst)
        (err_vld_i && !init_i && aw_en_i && dir == CLAMP_LO)
        |=> (integ_q >= $past(integ_q)));

    p_aw_high_r5: assert property (@(posedge clk) disable iff (rst)
        (err_vld_i && !init_i && aw_en_i && dir == CLAMP_HI)
        |=> (integ_q <= $past(integ_q)));

endmodule

bind pi_loop_reg pi_loop_chk #(.OUT_W(OUT_W), .ACC_W(ACC_W)) chk_i (
    .clk(clk), .rst(rst), .init_i(init_i), .aw_en_i(aw_en_i),
    .err_vld_i(err_vld_i), .y_min_i(y_min_i), .y_max_i(y_max_i),
    .y_vld_o(y_vld_o), .y_o(y_o), .integ_q(integ_q), .dir(dir)
);

// File: tb/pi_loop_reg_tb_top.sv
`timescale 1ns/1ps
module pi_loop_reg_tb_top;
    localparam int ERR_W  = 24;
    localparam int GAIN_W = 16;
    localparam int OUT_W  = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic init_i = 1'b0;
    logic aw_en_i = 1'b1;
    logic signed [GAIN_W-1:0] kp_i = '0;
    logic signed [GAIN_W-1:0] ki_i = '0;
    logic signed [OUT_W-1:0]  bias_i = '0;
    logic signed [OUT_W-1:0]  y_min_i = '0;
    logic signed [OUT_W-1:0]  y_max_i = 18'sd5000;
    logic err_vld_i = 1'b0;
    logic signed [ERR_W-1:0] err_i = '0;
    logic y_vld_o;
    logic signed [OUT_W-1:0] y_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    longint m_integ = 0;
    longint m_y = 0;
    bit     m_vld = 0;

    always #5 clk = ~clk;

    pi_loop_reg dut_i (
        .clk(clk), .rst(rst), .init_i(init_i), .aw_en_i(aw_en_i),
        .kp_i(kp_i), .ki_i(ki_i), .bias_i(bias_i), .y_min_i(y_min_i),
        .y_max_i(y_max_i), .err_vld_i(err_vld_i), .err_i(err_i),
        .y_vld_o(y_vld_o), .y_o(y_o)
    );

    task automatic compare(input string tag);
        n_chk++;
        if (y_vld_o !== m_vld || longint'(y_o) != m_y) begin
            n_bad++;
            $display("FAIL %s: vld=%0b y=%0d expected vld=%0b y=%0d",
                     tag, y_vld_o, y_o, m_vld, m_y);
        end
    endtask

    task automatic cfg(input int kp, input int ki, input int bias,
                       input int lo, input int hi, input bit aw);
        @(negedge clk);
        kp_i = GAIN_W'(kp); ki_i = GAIN_W'(ki); bias_i = OUT_W'(bias);
        y_min_i = OUT_W'(lo); y_max_i = OUT_W'(hi); aw_en_i = aw;
        err_vld_i = 1'b0; init_i = 1'b0;
        m_vld = 0;
        @(posedge clk); #1;
        compare("R9 config gap");
    endtask

    task automatic step(input bit v, input int e, input bit ini, input string tag);
        longint cand, p, raw, y;
        bit keep;
        @(negedge clk);
        err_vld_i = v; err_i = ERR_W'(e); init_i = ini;
        if (ini) begin
            m_integ = 0;
            m_vld = 0;
        end else if (v) begin
            cand = m_integ + e;
            p = cand * longint'(ki_i) + longint'(e) * longint'(kp_i);
            raw = (p >>> 12) + longint'(bias_i);
            if (raw < longint'(y_min_i)) begin
                y = y_min_i; keep = !aw_en_i || (cand > m_integ);
            end else if (raw > longint'(y_max_i)) begin
                y = y_max_i; keep = !aw_en_i || (cand < m_integ);
            end else begin
                y = raw; keep = 1;
            end
            m_y = y;
            if (keep) m_integ = cand;
            m_vld = 1;
        end else begin
            m_vld = 0;
        end
        @(posedge clk); #1;
        compare(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if (y_vld_o !== 1'b0 || y_o !== '0) begin
            n_bad++;
            $display("FAIL R1: vld=%0b y=%0d expected vld=0 y=0", y_vld_o, y_o);
        end
        @(negedge clk); rst = 1'b0;
        m_vld = 0; m_y = 0; m_integ = 0;

        // R2: pure proportional unity gain plus bias
        cfg(4096, 0, 1000, 0, 5000, 1);
        step(1, 100, 0, "R2 kp unity");
        step(1, -250, 0, "R2 kp negative");
        step(0, 0, 0, "R9 hold");
        step(0, 0, 0, "R9 hold again");
        // R10: floor rounding of the shift
        cfg(1, 0, 1000, 0, 5000, 1);
        step(1, -1, 0, "R10 floor -1");
        step(1, 1, 0, "R10 floor +1");
        step(1, -4097, 0, "R10 floor -4097");
        // R3: integral accumulation in range
        cfg(2048, 1024, 1000, 0, 5000, 1);
        step(1, 40, 0, "R3 integrate 1");
        step(1, 40, 0, "R3 integrate 2");
        step(0, 0, 0, "R9 gap");
        step(1, -20, 0, "R3 integrate 3");
        // R7: init clears integrator, settings remain
        step(0, 0, 1, "R7 init alone");
        step(1, 40, 0, "R7 after init");
        step(1, 500, 1, "R7 init with sample");
        step(1, 0, 0, "R7 zero err after init");
        // R5: drive into upper limit with anti-windup
        cfg(4096, 4096, 1000, 0, 5000, 1);
        for (int i = 0; i < 6; i++) step(1, 3000, 0, "R5 upper aw");
        step(1, -500, 0, "R5 recover aw");
        step(1, -500, 0, "R5 recover aw 2");
        // R4: drive into lower limit with anti-windup
        step(0, 0, 1, "R7 reinit");
        for (int i = 0; i < 6; i++) step(1, -3000, 0, "R4 lower aw");
        step(1, 400, 0, "R4 recover aw");
        step(1, 400, 0, "R4 recover aw 2");
        // R6: same stimulus with anti-windup off winds up
        cfg(4096, 4096, 1000, 0, 5000, 0);
        step(0, 0, 1, "R7 reinit");
        for (int i = 0; i < 6; i++) step(1, 3000, 0, "R6 upper windup");
        for (int i = 0; i < 4; i++) step(1, -500, 0, "R6 slow recovery");
        for (int i = 0; i < 6; i++) step(1, -3000, 0, "R6 lower windup");
        step(1, 400, 0, "R6 lower recovery");
        // R8: back-to-back and isolated strobes
        cfg(4096, 0, 0, -5000, 5000, 1);
        step(1, 7, 0, "R8 b2b 1");
        step(1, -7, 0, "R8 b2b 2");
        step(0, 0, 0, "R8 no strobe");
        step(1, 9, 0, "R8 isolated");
        step(0, 0, 0, "R8 no strobe 2");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule